// File: doc/BRIEF.md
# Video and Save Memory Access-Size Adapter

This block sits between a CPU load/store port and two memories with awkward widths: video memory, which is 16 bits wide, and battery-backed save SRAM, which is 8 bits wide. Each CPU access can be a byte, a halfword or a word. The block turns that access into the operation the memory really performs. It presents the result on a 32-bit lane-oriented memory bus with per-byte lane enables. When the memory returns read data, it shapes that data into the value the CPU receives.

Byte stores into video memory do not simply write one byte. In some sub-regions they are dropped. In others the byte is copied into both halves of the containing halfword. A bitmap-mode flag, sampled together with the store, moves the boundary between the background and object areas.

The save SRAM has only one byte per address. A wide read returns the addressed byte copied across the result. A wide write stores a single byte, picked from the write value by rotating it.

Each request is registered once before it reaches the memory bus. Read data returns to the CPU one cycle after the memory request.

Top module: `vidsave_size_adapter`

## Requirements
- R1: Halfword and word stores to video memory (palette 0x0500_0000–0x0500_03FF, BG, OBJ, OAM 0x0700_0000–0x0700_03FF) are performed normally.
  - A word store drives all four lane enables, with the address aligned to 4.
  - A halfword store drives lanes {1,0} when address bit 1 is 0 and lanes {3,2} when it is 1, with the halfword repeated in both halves of mem_wdata.
  - Lane i always carries byte i of the 32-bit bus.
- R2: A byte store into the OBJ area issues no memory request (mem_valid stays low). The OBJ area is 0x0601_0000–0x0601_7FFF when bitmap mode is off and 0x0601_4000–0x0601_7FFF when it is on.
- R3: A byte store into OAM issues no memory request.
- R4: A byte store into the BG area or the palette is issued as a halfword write at the address with bit 0 cleared.
  - Both lanes of that halfword are enabled, and every lane of mem_wdata carries the byte.
  - The BG area is 0x0600_0000–0x0600_FFFF when bitmap mode is off and 0x0600_0000–0x0601_3FFF when it is on.
- R5: The bitmap-mode flag is taken in the same cycle as the request. For example, a byte store to 0x0601_2001 is dropped when the flag is 0 and duplicated when it is 1.
- R6: Reads of save SRAM (0x0E00_0000–0x0FFF_FFFF) return the addressed byte B, taken from lane address[1:0] of mem_rdata.
  - A halfword read returns B×0x0101.
  - A word read returns B×0x0101_0101.
- R7: A halfword or word store to save SRAM enables only lane address[1:0], keeps the full byte address, and stores the low byte of (write value rotated right by 8×address[1:0]).
- R8: Byte loads and stores to save SRAM pass unchanged. The store writes write-data bits 7:0 into lane address[1:0]. The load returns that lane's byte zero-extended.
- R9: All other accesses pass through by size.
  - A byte store enables lane address[1:0].
  - Loads return the zero-extended lane byte, the lane halfword selected by address bit 1, or the full word.
  - Size encoding: 0 byte, 1 halfword, 2 or 3 word.
- R10: mem_valid rises in the cycle after a request that is not dropped. cpu_rvalid, with cpu_rdata, follows one cycle after a read request on the memory bus, while mem_rdata is presented.
- R11: After reset, mem_valid and cpu_rvalid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | ADDR_W | CPU byte address |
| req_wdata | input | DATA_W | CPU store data, right-aligned |
| req_bitmap | input | 1 | Bitmap-mode flag, sampled with the request |
| mem_valid | output | 1 | Memory operation issued |
| mem_write | output | 1 | Memory operation is a write |
| mem_addr | output | ADDR_W | Memory byte address after alignment |
| mem_be | output | DATA_W/8 | Lane enables |
| mem_wdata | output | DATA_W | Lane-positioned write data |
| mem_rdata | input | DATA_W | Lane-positioned read data, one cycle after a read request |
| cpu_rvalid | output | 1 | Read result valid |
| cpu_rdata | output | DATA_W | Shaped read result |

## Verification
The assertions check the following on every cycle:
- the one-cycle request-to-bus and bus-to-result timing;
- that byte stores to OAM never reach the bus;
- that any SRAM write enables exactly one lane;
- that palette byte stores duplicate the byte across a two-lane halfword;
- that word stores to video use all lanes.

Only the bench scenarios can show the following:
- the exact lane chosen by the rotation rule for wide SRAM stores;
- the replicated values of SRAM reads;
- how the bitmap flag moves the BG/OBJ boundary around 0x0601_0000–0x0601_7FFF.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

  typedef enum logic [2:0] {
    RGN_OTHER = 3'd0,
    RGN_BG    = 3'd1,
    RGN_OBJ   = 3'd2,
    RGN_OAM   = 3'd3,
    RGN_PAL   = 3'd4,
    RGN_SRAM  = 3'd5
  } region_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [31:0] PAL_LO      = 32'h0500_0000;
  localparam logic [31:0] PAL_HI      = 32'h0500_03FF;
  localparam logic [31:0] BG_LO       = 32'h0600_0000;
  localparam logic [31:0] BG_HI_TILE  = 32'h0600_FFFF;
  localparam logic [31:0] BG_HI_BMP   = 32'h0601_3FFF;
  localparam logic [31:0] OBJ_HI      = 32'h0601_7FFF;
  localparam logic [31:0] OAM_LO      = 32'h0700_0000;
  localparam logic [31:0] OAM_HI      = 32'h0700_03FF;
  localparam logic [31:0] SRAM_LO     = 32'h0E00_0000;
  localparam logic [31:0] SRAM_HI     = 32'h0FFF_FFFF;

endpackage

// File: rtl/vsa_region_decode.sv
module vsa_region_decode
  import vsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              bitmap,
  output region_e           region
);

  logic [ADDR_W-1:0] bg_top;

  assign bg_top = bitmap ? ADDR_W'(BG_HI_BMP) : ADDR_W'(BG_HI_TILE);

  always_comb begin
    region = RGN_OTHER;
    if (addr >= ADDR_W'(PAL_LO) && addr <= ADDR_W'(PAL_HI))
      region = RGN_PAL;
    else if (addr >= ADDR_W'(BG_LO) && addr <= bg_top)
      region = RGN_BG;
    else if (addr > bg_top && addr <= ADDR_W'(OBJ_HI))
      region = RGN_OBJ;
    else if (addr >= ADDR_W'(OAM_LO) && addr <= ADDR_W'(OAM_HI))
      region = RGN_OAM;
    else if (addr >= ADDR_W'(SRAM_LO) && addr <= ADDR_W'(SRAM_HI))
      region = RGN_SRAM;
  end

endmodule

// File: rtl/vsa_store_shape.sv
module vsa_store_shape
  import vsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  region_e                 region,
  input  logic [1:0]              size,
  input  logic                    write,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    keep,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [DATA_W/8-1:0]     be,
  output logic [DATA_W-1:0]       wdata_o
);

  localparam int LANES = DATA_W / 8;
  localparam int LSB_W = $clog2(LANES);

  logic [LSB_W-1:0]  lo;
  logic [7:0]        byte_val;
  logic [LANES-1:0]  be_byte;
  logic [LANES-1:0]  be_half;
  logic [DATA_W-1:0] rep_byte;
  logic [DATA_W-1:0] rep_half;
  logic [ADDR_W-1:0] addr_half;
  logic [ADDR_W-1:0] addr_word;
  logic              is_sram;

  assign lo        = addr[LSB_W-1:0];
  assign is_sram   = (region == RGN_SRAM);
  // wide SRAM store: rotating right by 8*lo leaves lane lo in the low byte
  assign byte_val  = (is_sram && size != SZ_BYTE) ? wdata[8*lo +: 8] : wdata[7:0];
  assign addr_half = {addr[ADDR_W-1:1], 1'b0};
  assign addr_word = addr & ~ADDR_W'(LANES - 1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_byte[i]          = (lo == LSB_W'(i));
    assign be_half[i]          = ((lo >> 1) == (LSB_W'(i) >> 1));
    assign rep_byte[8*i +: 8]  = byte_val;
    assign rep_half[8*i +: 8]  = wdata[8*(i%2) +: 8];
  end

  always_comb begin
    keep    = 1'b1;
    addr_o  = addr;
    be      = be_byte;
    wdata_o = rep_byte;
    if (!is_sram) begin
      case (size)
        SZ_BYTE: begin
          if (write && (region == RGN_OBJ || region == RGN_OAM)) begin
            keep = 1'b0;
          end else if (write && (region == RGN_BG || region == RGN_PAL)) begin
            addr_o = addr_half;
            be     = be_half;
          end
        end
        SZ_HALF: begin
          addr_o  = addr_half;
          be      = be_half;
          wdata_o = rep_half;
        end
        default: begin
          addr_o  = addr_word;
          be      = '1;
          wdata_o = wdata;
        end
      endcase
    end
  end

endmodule

// File: rtl/vsa_load_shape.sv
module vsa_load_shape
  import vsa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        is_sram,
  input  logic [1:0]                  size,
  input  logic [$clog2(DATA_W/8)-1:0] lo,
  input  logic [DATA_W-1:0]           rdata_in,
  output logic [DATA_W-1:0]           rdata
);

  localparam int LANES = DATA_W / 8;

  logic [7:0]        lane_byte;
  logic [15:0]       lane_half;
  logic [DATA_W-1:0] rep_byte;

  assign lane_byte = rdata_in[8*lo +: 8];
  assign lane_half = rdata_in[16*(lo >> 1) +: 16];

  for (genvar i = 0; i < LANES; i++) begin : g_rep
    assign rep_byte[8*i +: 8] = lane_byte;
  end

  always_comb begin
    case (size)
      SZ_BYTE: rdata = DATA_W'(lane_byte);
      SZ_HALF: rdata = is_sram ? DATA_W'({lane_byte, lane_byte}) : DATA_W'(lane_half);
      default: rdata = is_sram ? rep_byte : rdata_in;
    endcase
  end

endmodule

// File: rtl/vidsave_size_adapter.sv
module vidsave_size_adapter
  import vsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                req_bitmap,
  output logic                mem_valid,
  output logic                mem_write,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                cpu_rvalid,
  output logic [DATA_W-1:0]   cpu_rdata
);

  localparam int LANES = DATA_W / 8;
  localparam int LSB_W = $clog2(LANES);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  region_e           region;
  logic              keep;
  logic [ADDR_W-1:0] shp_addr;
  logic [LANES-1:0]  shp_be;
  logic [DATA_W-1:0] shp_wdata;

  vsa_region_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (req_addr),
    .bitmap (req_bitmap),
    .region (region)
  );

  vsa_store_shape #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .region  (region),
    .size    (req_size),
    .write   (req_write),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .keep    (keep),
    .addr_o  (shp_addr),
    .be      (shp_be),
    .wdata_o (shp_wdata)
  );

  // memory-side stage
  logic              mv_d, mv_q;
  logic              mw_q;
  logic [ADDR_W-1:0] ma_q;
  logic [LANES-1:0]  mb_q;
  logic [DATA_W-1:0] md_q;
  logic              m_sram_q;
  logic [1:0]        m_size_q;
  logic [LSB_W-1:0]  m_lo_q;
  logic              m_en;

  // read-return stage
  logic              rv_d, rv_q;
  logic              r_sram_q;
  logic [1:0]        r_size_q;
  logic [LSB_W-1:0]  r_lo_q;
  logic              r_en;

  always_comb begin
    mv_d = req_valid && keep;
    m_en = req_valid;
    rv_d = mv_q && !mw_q;
    r_en = mv_q && !mw_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mv_q     <= 1'b0;
      mw_q     <= 1'b0;
      ma_q     <= '0;
      mb_q     <= '0;
      md_q     <= '0;
      m_sram_q <= 1'b0;
      m_size_q <= '0;
      m_lo_q   <= '0;
      rv_q     <= 1'b0;
      r_sram_q <= 1'b0;
      r_size_q <= '0;
      r_lo_q   <= '0;
    end else begin
      mv_q <= mv_d;
      rv_q <= rv_d;
      if (m_en) begin
        mw_q     <= req_write;
        ma_q     <= shp_addr;
        mb_q     <= shp_be;
        md_q     <= shp_wdata;
        m_sram_q <= (region == RGN_SRAM);
        m_size_q <= req_size;
        m_lo_q   <= req_addr[LSB_W-1:0];
      end
      if (r_en) begin
        r_sram_q <= m_sram_q;
        r_size_q <= m_size_q;
        r_lo_q   <= m_lo_q;
      end
    end
  end

  vsa_load_shape #(.DATA_W(DATA_W)) u_load (
    .is_sram  (r_sram_q),
    .size     (r_size_q),
    .lo       (r_lo_q),
    .rdata_in (mem_rdata),
    .rdata    (cpu_rdata)
  );

  assign mem_valid  = mv_q;
  assign mem_write  = mw_q;
  assign mem_addr   = ma_q;
  assign mem_be     = mb_q;
  assign mem_wdata  = md_q;
  assign cpu_rvalid = rv_q;

endmodule

// File: rtl/vsa_checks.sv
module vsa_checks
  import vsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [1:0]          req_size,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                mem_valid,
  input logic                mem_write,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                cpu_rvalid
);

  logic byte_store, word_store, in_oam, in_pal, in_video, mem_in_sram;

  assign byte_store  = req_valid && req_write && req_size == SZ_BYTE;
  assign word_store  = req_valid && req_write && req_size[1];
  assign in_oam      = req_addr >= ADDR_W'(OAM_LO) && req_addr <= ADDR_W'(OAM_HI);
  assign in_pal      = req_addr >= ADDR_W'(PAL_LO) && req_addr <= ADDR_W'(PAL_HI);
  assign in_video    = in_pal || in_oam ||
                       (req_addr >= ADDR_W'(BG_LO) && req_addr <= ADDR_W'(OBJ_HI));
  assign mem_in_sram = mem_addr >= ADDR_W'(SRAM_LO) && mem_addr <= ADDR_W'(SRAM_HI);

  assert_mem_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> $past(req_valid));

  assert_rvalid_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(mem_valid && !mem_write));

  assert_oam_byte_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_store && in_oam) |=> !mem_valid);

  assert_sram_single_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && mem_in_sram) |-> $countones(mem_be) == 1);

  assert_pal_byte_dup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_store && in_pal) |=>
      (!mem_valid || (mem_wdata[7:0] == mem_wdata[15:8] && $countones(mem_be) == 2)));

  assert_video_word_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_store && in_video) |=> (!mem_valid || mem_be == '1));

endmodule

bind vidsave_size_adapter vsa_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_size   (req_size),
  .req_addr   (req_addr),
  .mem_valid  (mem_valid),
  .mem_write  (mem_write),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata),
  .cpu_rvalid (cpu_rvalid)
);

// File: tb/vidsave_size_adapter_tb.sv
module vidsave_size_adapter_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write, req_bitmap;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        mem_valid, mem_write, cpu_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, cpu_rdata;
  logic [3:0]  mem_be;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  vidsave_size_adapter u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bitmap(req_bitmap),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 other, 1 bg, 2 obj, 3 oam, 4 pal, 5 sram
  function automatic int area(input logic [31:0] a, input logic bm);
    logic [31:0] bg_end;
    bg_end = bm ? 32'h0601_3FFF : 32'h0600_FFFF;
    if (a >= 32'h0500_0000 && a <= 32'h0500_03FF) return 4;
    if (a >= 32'h0600_0000 && a <= bg_end)        return 1;
    if (a > bg_end && a <= 32'h0601_7FFF)         return 2;
    if (a >= 32'h0700_0000 && a <= 32'h0700_03FF) return 3;
    if (a >= 32'h0E00_0000 && a <= 32'h0FFF_FFFF) return 5;
    return 0;
  endfunction

  function automatic string tag_of(input bit wr, input int ar, input logic [1:0] sz);
    if (ar == 5) return (sz == 0) ? "R8" : (wr ? "R7" : "R6");
    if (wr && sz == 0 && ar == 2) return "R2";
    if (wr && sz == 0 && ar == 3) return "R3";
    if (wr && sz == 0 && (ar == 1 || ar == 4)) return "R4";
    if (wr && sz != 0 && ar != 0) return "R1";
    return "R9";
  endfunction

  task automatic run_op(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input logic bm, input logic [31:0] rword,
                        input string force_tag);
    int          ar;
    bit          keep;
    logic [31:0] ea, ew, er;
    logic [3:0]  eb;
    logic [7:0]  b, rb;
    logic [15:0] rh;
    string       tg;
    ar = area(a, bm);
    tg = (force_tag != "") ? force_tag : tag_of(wr, ar, sz);
    keep = 1; ea = a; eb = 4'b0001 << a[1:0];
    b  = d[7:0];
    if (ar == 5 && sz != 0) b = 8'((d >> (8 * a[1:0])) | (d << (32 - 8 * a[1:0])));
    ew = {4{b}};
    if (ar != 5) begin
      if (sz == 0) begin
        if (wr && (ar == 2 || ar == 3)) keep = 0;
        else if (wr && (ar == 1 || ar == 4)) begin
          ea = {a[31:1], 1'b0}; eb = a[1] ? 4'hC : 4'h3;
        end
      end else if (sz == 1) begin
        ea = {a[31:1], 1'b0}; eb = a[1] ? 4'hC : 4'h3; ew = {2{d[15:0]}};
      end else begin
        ea = {a[31:2], 2'b00}; eb = 4'hF; ew = d;
      end
    end
    rb = rword[8*a[1:0] +: 8];
    rh = a[1] ? rword[31:16] : rword[15:0];
    if (sz == 0)       er = {24'h0, rb};
    else if (ar == 5)  er = (sz == 1) ? {16'h0, rb, rb} : {4{rb}};
    else if (sz == 1)  er = {16'h0, rh};
    else               er = rword;

    @(negedge clk);
    check(mem_valid == 1'b0, "R10 idle before request", {79'h0, mem_valid}, 80'h0);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d; req_bitmap = bm;
    @(negedge clk);
    req_valid = 0; req_bitmap = ~bm;
    if (!keep)
      check(mem_valid == 1'b0, tg, {79'h0, mem_valid}, 80'h0);
    else if (wr)
      check(mem_valid && mem_write && mem_addr == ea && mem_be == eb && mem_wdata == ew, tg,
            {mem_valid, mem_write, 10'h0, mem_addr, mem_be, mem_wdata},
            {2'b11, 10'h0, ea, eb, ew});
    else begin
      check(mem_valid && !mem_write && mem_addr == ea && mem_be == eb, tg,
            {mem_valid, mem_write, 42'h0, mem_addr, mem_be}, {2'b10, 42'h0, ea, eb});
      mem_rdata = rword;
      @(negedge clk);
      check(cpu_rvalid && cpu_rdata == er, {tg, " read data R10"},
            {47'h0, cpu_rvalid, cpu_rdata}, {47'h0, 1'b1, er});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [7];
    logic [31:0] spans [7];
    void'($urandom(32'h0000_5EED));
    rst_n = 0; req_valid = 0; req_write = 0; req_size = 0; req_addr = 0;
    req_wdata = 0; req_bitmap = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!mem_valid && !cpu_rvalid, "R11 reset state", {78'h0, mem_valid, cpu_rvalid}, 80'h0);

    // directed corners
    run_op(1, 32'h0601_2001, 0, 32'h0000_00C3, 0, 0, "R5 obj drop");
    run_op(1, 32'h0601_2001, 0, 32'h0000_00C3, 1, 0, "R5 bg dup");
    run_op(1, 32'h0601_4000, 0, 32'h0000_0011, 1, 0, "R2 bitmap obj start");
    run_op(1, 32'h0601_0000, 0, 32'h0000_0011, 0, 0, "R2 obj start");
    run_op(1, 32'h0600_FFFF, 0, 32'h0000_0077, 0, 0, "R4 bg end");
    run_op(1, 32'h0700_03FF, 0, 32'h0000_0055, 0, 0, "R3 oam end");
    run_op(1, 32'h0700_0400, 0, 32'h0000_0055, 0, 0, "R9 past oam");
    run_op(1, 32'h0500_0003, 0, 32'h0000_00AB, 0, 0, "R4 palette");
    run_op(1, 32'h0700_0002, 1, 32'h0000_BEEF, 0, 0, "R1 oam half");
    run_op(1, 32'h0601_0004, 2, 32'hCAFE_F00D, 0, 0, "R1 obj word");
    run_op(1, 32'h0E00_0002, 2, 32'h1122_3344, 0, 0, "R7 word rotate");
    run_op(1, 32'h0E00_0003, 1, 32'h0000_A1B2, 0, 0, "R7 half rotate");
    run_op(1, 32'h0E00_0001, 0, 32'hFFFF_FF9C, 0, 0, "R8 byte store");
    run_op(0, 32'h0E00_0001, 1, 32'h0,         0, 32'h0000_5A00, "R6 half read");
    run_op(0, 32'h0E00_0001, 2, 32'h0,         0, 32'h0000_5A00, "R6 word read");
    run_op(0, 32'h0E00_0003, 0, 32'h0,         0, 32'h8D00_0000, "R8 byte read");
    run_op(0, 32'h0600_0002, 1, 32'h0,         0, 32'h1234_5678, "R9 video half read");

    // random mix
    bases = '{32'h0500_0000, 32'h0600_0000, 32'h0601_0000, 32'h0700_0000,
              32'h0E00_0000, 32'h0200_0000, 32'h0601_8000};
    spans = '{32'h400, 32'h14000, 32'h8000, 32'h400, 32'h10000, 32'h1000, 32'h100};
    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom % 7);
      run_op(bit'($urandom % 2), bases[k] + ($urandom % spans[k]), 2'($urandom % 4),
             $urandom, 1'($urandom % 2), $urandom, "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule